// File: doc/BRIEF.md
# I2C Slave Receive Controller

This block is the receive half of an I2C target device. It samples the two bus lines through synchronisers on the system clock. It detects start, repeated start and stop conditions and shifts in the first byte after each start. The top seven bits of that byte are compared against a small set of configurable target addresses, the general call address (all zeros) and a fixed host address. When a write request (R/W = 0) hits an enabled entry, the block sets the match flag for that single entry. It answers the ninth clock with an acknowledge whose polarity software selects. It then delivers the address byte and each following data byte through one receive data register.

Software polls a full flag and reads the register; each read empties it. The first read after a match gives back the address byte, which software throws away. If software falls behind, the block holds SCL low from the falling edge of the eighth clock of the next byte. The ninth clock therefore cannot begin until the register has been read, so no byte is ever overwritten. A stop condition clears the match flags and raises a sticky stop flag that software clears. A byte that is still unread stays available after the stop. Both bus lines are driven open-drain, each through a pull-low enable.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, both pull-low enables are 0, `rxFull`, `stopFlag` and every bit of `matchFlags` are 0.
- R2: On a write request whose 7-bit address hits an enabled entry, exactly one `matchFlags` bit is set on the ninth SCL rising edge of the address byte. Bits 0..NUM_SLOTS-1 belong to the slots, bit NUM_SLOTS to the general call address 0x00, and bit NUM_SLOTS+1 to HOST_ADDR (default 0x08). When several entries hit, the lowest bit wins.
- R3: During the ninth clock of a matched address byte and of every received data byte, `sdaPullLow` equals the inverse of `ackCtl`, so 0 means ACK. A matched address is still flagged and received when `ackCtl` is 1.
- R4: After a matched write address, `rxFull` rises and the first read of `rdData` returns the address byte as {address[6:0], R/W}.
- R5: Each data byte after the address, sent MSB first, is presented on `rdData` with `rxFull` set at its ninth SCL rising edge. A one-cycle `rdStrobe` clears `rxFull`.
- R6: If `rxFull` is still 1 at the falling edge of the eighth SCL of an accepted byte, `sclPullLow` goes high and stays high until `rdStrobe`. A byte is never loaded while `rxFull` is 1.
- R7: A stop condition (SDA rising while SCL is high) clears `matchFlags` and sets `stopFlag`. An unread byte keeps `rxFull` at 1 and its value on `rdData`.
- R8: `stopFlag` stays 1 until a `stopClr` pulse, including across a later start and address byte.
- R9: An address that hits no enabled entry, or a hit with R/W = 1, gets no ACK and sets no flag. The following bytes up to the next start or stop are neither acknowledged nor loaded.
- R10: A repeated start (SDA falling while SCL is high) restarts address reception, and the new address byte replaces `matchFlags`.
- R11: An entry whose enable is 0 (`slotEn` bit, `gcEn`, `hostEn`) never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclPullLow | output | 1 | Pull SCL low (clock stretch) |
| sdaPullLow | output | 1 | Pull SDA low (acknowledge) |
| slotAddr | input | 7*NUM_SLOTS | Slot addresses, slot i in bits [7i+6:7i] |
| slotEn | input | NUM_SLOTS | Per-slot match enable |
| gcEn | input | 1 | General call match enable |
| hostEn | input | 1 | Host address match enable |
| ackCtl | input | 1 | Acknowledge value for the ninth clock, 0 = ACK |
| rdStrobe | input | 1 | One-cycle read of the receive data register |
| rdData | output | 8 | Receive data register |
| rxFull | output | 1 | Receive data register holds an unread byte |
| stopClr | input | 1 | Clears the stop flag |
| stopFlag | output | 1 | Sticky stop-detected flag |
| matchFlags | output | NUM_SLOTS+2 | Per-entry address match flags |

## Verification
The bench uses the default build of three slots with the host address at 0x08. It gives two slots the same address, which brings the priority rule within reach. It then sweeps all 128 seven-bit addresses, each as a separate write transaction. For every address the bench works out the expected flag, the acknowledge and the dummy byte arithmetically. Directed transfers follow for data ordering, clock stretching against a master that honours SCL, stop with a byte left pending, the sticky stop flag, repeated start, read requests and disabled entries.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

  // Bus happenings decoded by the datapath, consumed by the control.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic rwBit;
  } busEvt_t;

  // Strobes the control issues to the datapath.
  typedef struct packed {
    logic shiftEn;
    logic loadData;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rxState_t;

endpackage

// File: rtl/i2c_srx_datapath.sv
module i2c_srx_datapath
  import i2c_srx_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int ADDR_W    = 7,
  parameter logic [6:0] HOST_ADDR = 7'h08,
  localparam int BYTE_W  = ADDR_W + 1,
  localparam int FLAG_W  = NUM_SLOTS + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  input  logic [ADDR_W*NUM_SLOTS-1:0] slotAddr,
  input  logic [NUM_SLOTS-1:0]        slotEn,
  input  logic                        gcEn,
  input  logic                        hostEn,
  input  dpStrobe_t                   strobe,
  output busEvt_t                     evt,
  output logic [FLAG_W-1:0]           matchVec,
  output logic [BYTE_W-1:0]           rdData
);

  logic sclMeta, sclSync, sclPrev;
  logic sdaMeta, sdaSync, sdaPrev;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] rxData;

  // Two-flop synchronisers plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclSync <= 1'b1; sclPrev <= 1'b1;
      sdaMeta <= 1'b1; sdaSync <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclMeta <= sclIn; sclSync <= sclMeta; sclPrev <= sclSync;
      sdaMeta <= sdaIn; sdaSync <= sdaMeta; sdaPrev <= sdaSync;
    end
  end

  assign evt.sclRise  = sclSync && !sclPrev;
  assign evt.sclFall  = !sclSync && sclPrev;
  assign evt.startDet = sclSync && sclPrev && sdaPrev && !sdaSync;
  assign evt.stopDet  = sclSync && sclPrev && !sdaPrev && sdaSync;
  assign evt.rwBit    = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
    end else begin
      if (strobe.shiftEn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaSync};
      if (strobe.loadData) rxData   <= shiftReg;
    end
  end

  assign rdData = rxData;

  // Priority compare: lowest slot first, then general call, then host.
  always_comb begin
    logic found;
    matchVec = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && slotEn[i] &&
          shiftReg[BYTE_W-1:1] == slotAddr[i*ADDR_W +: ADDR_W]) begin
        matchVec[i] = 1'b1;
        found       = 1'b1;
      end
    end
    if (!found && gcEn && shiftReg[BYTE_W-1:1] == '0) begin
      matchVec[NUM_SLOTS] = 1'b1;
      found               = 1'b1;
    end
    if (!found && hostEn && shiftReg[BYTE_W-1:1] == HOST_ADDR[ADDR_W-1:0])
      matchVec[NUM_SLOTS+1] = 1'b1;
  end

  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |-> evt.sclRise);  // R5

  AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadData |-> (evt.sclRise && !evt.startDet && !evt.stopDet));  // R5

  AST_ONE_CANDIDATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));  // R2

endmodule

// File: rtl/i2c_srx_control.sv
module i2c_srx_control
  import i2c_srx_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int BYTE_BITS = 8,
  localparam int FLAG_W   = NUM_SLOTS + 2,
  localparam int CNT_W    = $clog2(BYTE_BITS + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [FLAG_W-1:0] matchVec,
  input  logic              ackCtl,
  input  logic              rdStrobe,
  input  logic              stopClr,
  output dpStrobe_t         strobe,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic              rxFull,
  output logic              stopFlag,
  output logic [FLAG_W-1:0] matchFlags
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_BITS + 1);

  rxState_t          state;
  logic [CNT_W-1:0]  bitCnt;
  logic              accept;
  logic [FLAG_W-1:0] matchHold;
  logic              sclHold, sdaHold;
  logic              active, quiet, addrOk;

  assign active = (state == ST_ADDR) || (state == ST_DATA);
  assign quiet  = !evt.startDet && !evt.stopDet;
  assign addrOk = (|matchVec) && !evt.rwBit;

  assign strobe.shiftEn  = active && quiet && evt.sclRise && (bitCnt < LAST_BIT);
  assign strobe.loadData = active && quiet && evt.sclRise && (bitCnt == LAST_BIT) && accept;

  assign sclPullLow = sclHold;
  assign sdaPullLow = sdaHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      accept     <= 1'b0;
      matchHold  <= '0;
      matchFlags <= '0;
      sclHold    <= 1'b0;
      sdaHold    <= 1'b0;
      rxFull     <= 1'b0;
      stopFlag   <= 1'b0;
    end else begin
      if (strobe.loadData) rxFull <= 1'b1;
      else if (rdStrobe)   rxFull <= 1'b0;

      if (evt.stopDet)  stopFlag <= 1'b1;
      else if (stopClr) stopFlag <= 1'b0;

      if (rdStrobe) sclHold <= 1'b0;

      if (evt.stopDet) begin
        state      <= ST_IDLE;
        matchFlags <= '0;
        sdaHold    <= 1'b0;
        sclHold    <= 1'b0;
        bitCnt     <= '0;
        accept     <= 1'b0;
      end else if (evt.startDet) begin
        state   <= ST_ADDR;
        sdaHold <= 1'b0;
        sclHold <= 1'b0;
        bitCnt  <= '0;
        accept  <= 1'b0;
      end else if (active) begin
        if (evt.sclRise) begin
          if (bitCnt < LAST_BIT) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (bitCnt == LAST_BIT) begin
            bitCnt <= ACK_BIT;
            if (state == ST_ADDR) matchFlags <= matchHold;
          end
        end
        if (evt.sclFall) begin
          if (bitCnt == LAST_BIT) begin
            // Ack phase opens: decide acceptance, acknowledge and stretch.
            if (state == ST_ADDR) begin
              accept    <= addrOk;
              matchHold <= addrOk ? matchVec : '0;
              sdaHold   <= addrOk && !ackCtl;
              if (addrOk && rxFull && !rdStrobe) sclHold <= 1'b1;
            end else begin
              accept  <= 1'b1;
              sdaHold <= !ackCtl;
              if (rxFull && !rdStrobe) sclHold <= 1'b1;
            end
          end else if (bitCnt == ACK_BIT) begin
            sdaHold <= 1'b0;
            bitCnt  <= '0;
            if (state == ST_ADDR) state <= accept ? ST_DATA : ST_SKIP;
          end
        end
      end
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadData |-> !rxFull);  // R6

  AST_HOLD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    sclPullLow |-> rxFull);  // R6

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchFlags));  // R2

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopDet |=> (matchFlags == '0 && stopFlag));  // R7

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strobe.loadData) |=> !rxFull);  // R5

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stopFlag && !stopClr) |=> stopFlag);  // R8

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter logic [6:0] HOST_ADDR = 7'h08,
  localparam int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int FLAG_W = NUM_SLOTS + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sclPullLow,
  output logic                        sdaPullLow,
  input  logic [ADDR_W*NUM_SLOTS-1:0] slotAddr,
  input  logic [NUM_SLOTS-1:0]        slotEn,
  input  logic                        gcEn,
  input  logic                        hostEn,
  input  logic                        ackCtl,
  input  logic                        rdStrobe,
  output logic [BYTE_W-1:0]           rdData,
  output logic                        rxFull,
  input  logic                        stopClr,
  output logic                        stopFlag,
  output logic [FLAG_W-1:0]           matchFlags
);

  busEvt_t           evt;
  dpStrobe_t         strobe;
  logic [FLAG_W-1:0] matchVec;

  i2c_srx_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),
    .HOST_ADDR(HOST_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .slotAddr(slotAddr),
    .slotEn  (slotEn),
    .gcEn    (gcEn),
    .hostEn  (hostEn),
    .strobe  (strobe),
    .evt     (evt),
    .matchVec(matchVec),
    .rdData  (rdData)
  );

  i2c_srx_control #(
    .NUM_SLOTS(NUM_SLOTS),
    .BYTE_BITS(BYTE_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .matchVec  (matchVec),
    .ackCtl    (ackCtl),
    .rdStrobe  (rdStrobe),
    .stopClr   (stopClr),
    .strobe    (strobe),
    .sclPullLow(sclPullLow),
    .sdaPullLow(sdaPullLow),
    .rxFull    (rxFull),
    .stopFlag  (stopFlag),
    .matchFlags(matchFlags)
  );

endmodule

// File: tb/i2c_slave_rx_test.sv
`timescale 1ns/1ps
module i2c_slave_rx_test;

  localparam int NS = 3;
  localparam int FW = NS + 2;
  localparam int Q  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclPullLow, sdaPullLow;
  logic sclLine, sdaLine;
  logic [7*NS-1:0] slotAddr;
  logic [NS-1:0] slotEn;
  logic gcEn, hostEn, ackCtl, rdStrobe, stopClr;
  logic [7:0] rdData;
  logic rxFull, stopFlag;
  logic [FW-1:0] matchFlags;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign sclLine = !(mSclLow || sclPullLow);
  assign sdaLine = !(mSdaLow || sdaPullLow);

  i2c_slave_rx #(.NUM_SLOTS(NS)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .slotAddr(slotAddr), .slotEn(slotEn), .gcEn(gcEn), .hostEn(hostEn),
    .ackCtl(ackCtl), .rdStrobe(rdStrobe), .rdData(rdData), .rxFull(rxFull),
    .stopClr(stopClr), .stopFlag(stopFlag), .matchFlags(matchFlags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclUp();
    mSclLow = 1'b0;
    do waitCyc(1); while (!sclLine);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; waitCyc(Q);
    sclUp(); waitCyc(Q);
    mSdaLow = 1'b1; waitCyc(Q);
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; waitCyc(Q);
    sclUp(); waitCyc(Q);
    mSdaLow = 1'b0; waitCyc(Q);
  endtask

  task automatic busBit(input logic b, output logic s);
    mSdaLow = !b; waitCyc(Q);
    sclUp(); waitCyc(Q);
    s = sdaLine;
    mSclLow = 1'b1; waitCyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(v[i], s);
    busBit(1'b1, ack);
  endtask

  task automatic cpuRead(output logic [7:0] v);
    v = rdData;
    rdStrobe = 1'b1; waitCyc(1);
    rdStrobe = 1'b0; waitCyc(1);
  endtask

  task automatic clearStop();
    stopClr = 1'b1; waitCyc(1);
    stopClr = 1'b0; waitCyc(1);
  endtask

  function automatic logic [FW-1:0] expFlags(input logic [6:0] a);
    for (int i = 0; i < NS; i++)
      if (slotEn[i] && slotAddr[i*7 +: 7] == a) return FW'(1) << i;
    if (gcEn && a == 7'h00) return FW'(1) << NS;
    if (hostEn && a == 7'h08) return FW'(1) << (NS + 1);
    return '0;
  endfunction

  initial begin
    logic ack;
    logic [7:0] got;
    logic done;
    slotAddr = {7'h55, 7'h2A, 7'h2A};  // slot1 duplicates slot0
    slotEn = 3'b111; gcEn = 1'b1; hostEn = 1'b1;
    ackCtl = 1'b0; rdStrobe = 1'b0; stopClr = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    chk("R1 sclPullLow", sclPullLow, 0);
    chk("R1 sdaPullLow", sdaPullLow, 0);
    chk("R1 rxFull", rxFull, 0);
    chk("R1 stopFlag", stopFlag, 0);
    chk("R1 matchFlags", matchFlags, 0);

    // R2 R4 R9 sweep of every 7-bit address as a write
    for (int a = 0; a < 128; a++) begin
      logic [FW-1:0] ef;
      ef = expFlags(7'(a));
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      chk("R2 flags", matchFlags, ef);
      chk("R9 ack", ack, (ef == 0) ? 1 : 0);
      chk("R4 rxFull", rxFull, (ef != 0) ? 1 : 0);
      if (ef != 0) begin
        cpuRead(got);
        chk("R4 dummy byte", got, {7'(a), 1'b0});
        chk("R5 read clears", rxFull, 0);
      end
      busStop();
      chk("R7 flags cleared", matchFlags, 0);
      chk("R7 stopFlag", stopFlag, 1);
      clearStop();
      chk("R8 cleared", stopFlag, 0);
    end

    // R5 several data bytes in order
    busStart();
    sendByte({7'h55, 1'b0}, ack);
    cpuRead(got);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'(8'h3C + k * 8'h41);
      sendByte(d, ack);
      chk("R3 data ack", ack, 0);
      chk("R5 rxFull", rxFull, 1);
      cpuRead(got);
      chk("R5 data", got, d);
    end

    // R6 stretch: leave data unread, next byte must be held at ninth clock
    sendByte(8'h81, ack);
    done = 1'b0;
    fork
      begin sendByte(8'hA5, ack); done = 1'b1; end
      begin
        waitCyc(220);
        chk("R6 scl held", sclPullLow, 1);
        chk("R6 master blocked", done, 0);
        cpuRead(got);
        chk("R6 old byte", got, 8'h81);
      end
    join
    chk("R6 ack after release", ack, 0);
    chk("R6 new byte", rdData, 8'hA5);
    chk("R6 released", sclPullLow, 0);

    // R7 stop with byte pending
    busStop();
    chk("R7 flags cleared", matchFlags, 0);
    chk("R7 stopFlag", stopFlag, 1);
    chk("R7 pending full", rxFull, 1);
    chk("R7 pending data", rdData, 8'hA5);
    cpuRead(got);

    // R8 stop flag survives a new start and address
    busStart();
    sendByte({7'h2A, 1'b0}, ack);
    chk("R8 sticky", stopFlag, 1);
    chk("R2 priority low slot", matchFlags, 5'b00001);
    cpuRead(got);

    // R10 repeated start to another address
    busStart();
    sendByte({7'h55, 1'b0}, ack);
    chk("R10 new flags", matchFlags, 5'b00100);
    cpuRead(got);
    chk("R10 dummy", got, {7'h55, 1'b0});
    busStop();
    clearStop();
    chk("R8 cleared", stopFlag, 0);

    // R3 NACK by software, still matched
    ackCtl = 1'b1;
    busStart();
    sendByte({7'h08, 1'b0}, ack);
    chk("R3 nack", ack, 1);
    chk("R3 flag", matchFlags, 5'b10000);
    chk("R3 rxFull", rxFull, 1);
    cpuRead(got);
    sendByte(8'h5A, ack);
    chk("R3 data nack", ack, 1);
    cpuRead(got);
    chk("R3 data", got, 8'h5A);
    busStop();
    clearStop();
    ackCtl = 1'b0;

    // R9 read request to a matching address
    busStart();
    sendByte({7'h55, 1'b1}, ack);
    chk("R9 rw ack", ack, 1);
    chk("R9 rw flags", matchFlags, 0);
    chk("R9 rw rxFull", rxFull, 0);
    sendByte(8'hC3, ack);
    chk("R9 ignored ack", ack, 1);
    chk("R9 ignored rxFull", rxFull, 0);
    busStop();
    clearStop();

    // R11 disabled entries
    slotEn = 3'b011; gcEn = 1'b0;
    busStart();
    sendByte({7'h55, 1'b0}, ack);
    chk("R11 slot off ack", ack, 1);
    chk("R11 slot off flags", matchFlags, 0);
    busStart();
    sendByte({7'h00, 1'b0}, ack);
    chk("R11 gc off ack", ack, 1);
    chk("R11 gc off rxFull", rxFull, 0);
    busStop();
    clearStop();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule